// File: doc/BRIEF.md
# Frame buffer write DMA master

This block moves pixels from an upstream pixel FIFO into a linear frame buffer in system memory. Each 18-bit pixel carries 6-bit red, green and blue samples. The block reduces it to a 16-bit 5:6:5 value by dropping bits, with no dithering. Two such values are paired into each 32-bit memory word, and the words are written in bursts over a write-only address/data port that obeys a wait request.

The block starts a burst only once the FIFO fill level covers the whole burst. The memory side therefore never stalls waiting for pixels. A burst is at most `BURST_WORDS` words long and never runs past the end of the current line. Lines are stored back to back from a programmed start address.

Software sets up the block through a small word-indexed register port. The port holds:
- a run enable;
- the start address;
- the number of words per line and the number of lines per frame;
- a sticky frame-done flag, an interrupt enable and a write-one-to-clear register.

After the last word of a frame is accepted, the flag sets and the next frame starts again at the start address.

Top module: `fbw_dma`

## Requirements
- R1: After reset, `m_write`, `fifo_rd` and `irq` are low and every register index 0 to 6 reads as zero.
- R2: A burst of N words starts only when `fifo_level` is at least 2N, and the FIFO is never popped while it is empty.
- R3: An input pixel holds red in bits [17:12], green in [11:6] and blue in [5:0]. Its 16-bit form is {R[5:1], G[5:0], B[5:1]}. Each written word carries the earlier pixel in bits [15:0] and the later one in bits [31:16].
- R4: While `m_write` is high and `m_waitreq` is high, `m_write`, `m_addr` and `m_wdata` stay unchanged on the next cycle.
- R5: Word i of a frame is written at (start AND NOT 3) + 4i. `m_addr` bits [1:0] are always zero, and the start register (index 4) reads back as written.
- R6: A burst's length is the smaller of `BURST_WORDS` and the number of words left in the current line. The words-per-line count is set at index 5.
- R7: A frame ends after (words per line) × (lines per frame) accepted words, with lines per frame set at index 6 and a zero length acting as one. The frame-done flag is bit 3 of status index 1. The first word of the following frame goes to the start address again.
- R8: The enable is bit 0 of index 0. No burst begins while it is 0. Clearing it during a burst lets that burst finish, and setting it again resumes at the next word of the frame.
- R9: `irq` is high exactly when the frame-done flag is set and interrupt-enable bit 3 of index 2 is 1.
- R10: Writing a word with bit 3 set to index 3 clears the frame-done flag, and writing 0 there leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| fifo_level | input | LVL_W | Pixels currently held by the FIFO |
| fifo_data | input | 18 | Pixel at the FIFO head |
| fifo_rd | output | 1 | Pop one pixel |
| m_addr | output | 32 | Memory write byte address |
| m_write | output | 1 | Memory write request |
| m_wdata | output | 32 | Memory write data |
| m_waitreq | input | 1 | Memory not ready; hold the request |
| irq | output | 1 | Frame interrupt |

## Verification
The bench builds the block with `BURST_WORDS` = 4, a 9-bit fill level and 10/9-bit line and line-count widths. With these values a single frame fits in the FIFO, and lines of 1, 2, 3, 5 and 8 words give full bursts, bursts trimmed at a line end and one-word bursts. A 4-word burst needs eight pixels, so seven queued pixels probe the start threshold exactly. A wait request held two cycles in three exercises the hold behaviour on every word.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

  localparam int PIX_W = 18;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_WR
  } fbw_st_e;

  // 6:6:6 pixel to 5:6:5 by truncating red and blue
  function automatic logic [15:0] to565(input logic [PIX_W-1:0] p);
    return {p[17:13], p[11:6], p[5:1]};
  endfunction

endpackage

// File: rtl/fbw_regs.sv
module fbw_regs #(
  parameter int XW = 10,
  parameter int YW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          frame_evt,
  output logic          enable,
  output logic [31:0]   start_addr,
  output logic [XW-1:0] line_words,
  output logic [YW-1:0] line_count,
  output logic          done,
  output logic          irq
);

  logic ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable     <= 1'b0;
      ie_q       <= 1'b0;
      start_addr <= '0;
      line_words <= '0;
      line_count <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: enable     <= reg_wdata[0];
        3'd2: ie_q       <= reg_wdata[3];
        3'd4: start_addr <= reg_wdata;
        3'd5: line_words <= reg_wdata[XW-1:0];
        3'd6: line_count <= reg_wdata[YW-1:0];
        default: ;
      endcase
    end
  end

  // sticky flag: a completing frame takes priority over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      done <= 1'b0;
    else if (frame_evt)
      done <= 1'b1;
    else if (reg_we && reg_addr == 3'd3 && reg_wdata[3])
      done <= 1'b0;
  end

  assign irq = done & ie_q;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {31'b0, enable};
      3'd1:    reg_rdata = {28'b0, done, 3'b0};
      3'd2:    reg_rdata = {28'b0, ie_q, 3'b0};
      3'd4:    reg_rdata = start_addr;
      3'd5:    reg_rdata = {{(32-XW){1'b0}}, line_words};
      3'd6:    reg_rdata = {{(32-YW){1'b0}}, line_count};
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/fbw_pos.sv
module fbw_pos #(
  parameter int XW          = 10,
  parameter int YW          = 9,
  parameter int BURST_WORDS = 4,
  parameter int BW          = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [XW-1:0] line_words,
  input  logic [YW-1:0] line_count,
  output logic          at_top,
  output logic [BW-1:0] blen,
  output logic          frame_evt
);

  localparam logic [XW:0] BURST_X = (XW+1)'(BURST_WORDS);

  logic [XW-1:0] word_q;
  logic [YW-1:0] line_q;
  logic          last_word;
  logic          last_line;
  logic [XW:0]   rem;

  assign last_word = ({1'b0, word_q} + 1'b1) >= {1'b0, line_words};
  assign last_line = ({1'b0, line_q} + 1'b1) >= {1'b0, line_count};
  assign at_top    = (word_q == '0) && (line_q == '0);
  assign frame_evt = adv && last_word && last_line;

  always_comb begin
    rem = last_word ? (XW+1)'(1) : ({1'b0, line_words} - {1'b0, word_q});
    blen = (rem >= BURST_X) ? BW'(BURST_WORDS) : rem[BW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      line_q <= '0;
    end else if (adv) begin
      if (last_word) begin
        word_q <= '0;
        line_q <= last_line ? '0 : line_q + 1'b1;
      end else begin
        word_q <= word_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fbw_engine.sv
module fbw_engine
  import fbw_pkg::*;
#(
  parameter int LVL_W = 9,
  parameter int BW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [31:0]      start_addr,
  input  logic             at_top,
  input  logic [BW-1:0]    blen,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [PIX_W-1:0] fifo_data,
  input  logic             m_waitreq,
  output logic             fifo_rd,
  output logic [31:0]      m_addr,
  output logic             m_write,
  output logic [31:0]      m_wdata,
  output logic             adv,
  output logic             launch
);

  localparam int CW = LVL_W + BW + 1;

  fbw_st_e       st_q;
  logic [BW-1:0] left_q;
  logic [31:0]   addr_q;
  logic [31:0]   word_q;

  assign launch  = (st_q == ST_IDLE) && enable &&
                   (CW'(fifo_level) >= CW'({blen, 1'b0}));
  assign fifo_rd = (st_q == ST_LO) || (st_q == ST_HI);
  assign m_write = (st_q == ST_WR);
  assign adv     = m_write && !m_waitreq;
  assign m_addr  = addr_q;
  assign m_wdata = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      addr_q <= '0;
      word_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (launch) begin
          st_q   <= ST_LO;
          left_q <= blen;
          if (at_top) addr_q <= start_addr & ~32'h3;
        end
        ST_LO: begin
          word_q[15:0] <= to565(fifo_data);
          st_q         <= ST_HI;
        end
        ST_HI: begin
          word_q[31:16] <= to565(fifo_data);
          st_q          <= ST_WR;
        end
        ST_WR: if (!m_waitreq) begin
          addr_q <= addr_q + 32'd4;
          left_q <= left_q - BW'(1);
          st_q   <= (left_q > BW'(1)) ? ST_LO : ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fbw_dma.sv
module fbw_dma #(
  parameter int BURST_WORDS = 4,
  parameter int LVL_W       = 9,
  parameter int XW          = 10,
  parameter int YW          = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [17:0]      fifo_data,
  output logic             fifo_rd,
  output logic [31:0]      m_addr,
  output logic             m_write,
  output logic [31:0]      m_wdata,
  input  logic             m_waitreq,
  output logic             irq
);

  localparam int BW = $clog2(BURST_WORDS + 1);

  logic          enable;
  logic [31:0]   start_addr;
  logic [XW-1:0] line_words;
  logic [YW-1:0] line_count;
  logic          done;
  logic          frame_evt;
  logic          at_top;
  logic [BW-1:0] blen;
  logic          adv;
  logic          launch;

  fbw_regs #(.XW(XW), .YW(YW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .frame_evt(frame_evt),
    .enable(enable), .start_addr(start_addr),
    .line_words(line_words), .line_count(line_count),
    .done(done), .irq(irq)
  );

  fbw_pos #(.XW(XW), .YW(YW), .BURST_WORDS(BURST_WORDS), .BW(BW)) u_pos (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .line_words(line_words), .line_count(line_count),
    .at_top(at_top), .blen(blen), .frame_evt(frame_evt)
  );

  fbw_engine #(.LVL_W(LVL_W), .BW(BW)) u_eng (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_addr(start_addr),
    .at_top(at_top), .blen(blen), .fifo_level(fifo_level),
    .fifo_data(fifo_data), .m_waitreq(m_waitreq), .fifo_rd(fifo_rd),
    .m_addr(m_addr), .m_write(m_write), .m_wdata(m_wdata),
    .adv(adv), .launch(launch)
  );

endmodule

// File: rtl/fbw_dma_chk.sv
module fbw_dma_chk #(
  parameter int LVL_W = 9,
  parameter int BW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             launch,
  input logic [BW-1:0]    blen,
  input logic             enable,
  input logic [LVL_W-1:0] fifo_level,
  input logic             fifo_rd,
  input logic             m_write,
  input logic             m_waitreq,
  input logic [31:0]      m_addr,
  input logic [31:0]      m_wdata
);

  localparam int CW = LVL_W + BW + 1;

  p_launch_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> (CW'(fifo_level) >= CW'({blen, 1'b0})));

  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (fifo_level != '0));

  p_no_pop_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_write |-> !fifo_rd);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_write && m_waitreq) |=> (m_write && $stable(m_addr) && $stable(m_wdata)));

  p_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_write |-> (m_addr[1:0] == 2'b00));

  p_launch_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> enable);

endmodule

bind fbw_dma fbw_dma_chk #(.LVL_W(LVL_W), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .launch(launch), .blen(blen),
  .enable(enable), .fifo_level(fifo_level), .fifo_rd(fifo_rd),
  .m_write(m_write), .m_waitreq(m_waitreq),
  .m_addr(m_addr), .m_wdata(m_wdata)
);

// File: tb/tb_fbw_dma.sv
module tb_fbw_dma;

  localparam int CLK_PERIOD = 10;
  localparam int BURST      = 4;
  localparam int LVL_W      = 9;
  localparam int NV         = 4;
  localparam int V_START [NV] = '{32'h1000, 32'h2000, 32'h3006, 32'h4000};
  localparam int V_LW    [NV] = '{8, 5, 4, 1};
  localparam int V_LINES [NV] = '{4, 3, 2, 3};
  localparam int V_WAIT  [NV] = '{0, 1, 1, 0};
  localparam int V_IE    [NV] = '{1, 0, 1, 0};

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             rst_n = 1'b0;
  logic             reg_we = 1'b0;
  logic [2:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [LVL_W-1:0] fifo_level;
  logic [17:0]      fifo_data;
  logic             fifo_rd;
  logic [31:0]      m_addr;
  logic             m_write;
  logic [31:0]      m_wdata;
  logic             m_waitreq = 1'b0;
  logic             irq;

  fbw_dma #(.BURST_WORDS(BURST), .LVL_W(LVL_W), .XW(10), .YW(9)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_level(fifo_level),
    .fifo_data(fifo_data), .fifo_rd(fifo_rd), .m_addr(m_addr),
    .m_write(m_write), .m_wdata(m_wdata), .m_waitreq(m_waitreq), .irq(irq)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit wmode = 0;
  bit finished = 0;

  // FIFO model
  logic [17:0] fmem [0:4095];
  int wr_p = 0;
  int rd_p = 0;
  assign fifo_level = LVL_W'(wr_p - rd_p);
  assign fifo_data  = fmem[rd_p % 4096];
  always @(posedge clk) if (fifo_rd) rd_p <= rd_p + 1;

  // memory model: record accepted writes
  logic [31:0] cap_a [0:1023];
  logic [31:0] cap_d [0:1023];
  int ncap = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (m_write && !m_waitreq) begin
      cap_a[ncap % 1024] <= m_addr;
      cap_d[ncap % 1024] <= m_wdata;
      ncap <= ncap + 1;
    end
  end
  always @(negedge clk) m_waitreq <= wmode && (cyc % 3 != 0);

  function automatic logic [17:0] pxv(int n);
    return 18'((n * 40503 + 1111) ^ (n >>> 3));
  endfunction

  function automatic logic [15:0] e565(logic [17:0] p);
    int r, g, b;
    r = (p >> 12) & 63;
    g = (p >> 6) & 63;
    b = p & 63;
    return 16'((r / 2) * 2048 + g * 32 + b / 2);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(int a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 d = reg_rdata;
  endtask

  task automatic push(int n);
    for (int i = 0; i < n; i++) begin
      fmem[wr_p % 4096] = pxv(wr_p);
      wr_p++;
    end
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd_reg(1, v);
      if (v[3]) break;
    end
  endtask

  task automatic setup(logic [31:0] st, int lw, int ln, int ie);
    wr_reg(0, 0);
    wr_reg(4, st);
    wr_reg(5, lw);
    wr_reg(6, ln);
    wr_reg(2, ie ? 32'h8 : 32'h0);
  endtask

  task automatic clear_done();
    wr_reg(0, 0);
    wr_reg(3, 32'h8);
  endtask

  // compare n captured writes from base against pixels from g0, addresses from a0
  task automatic cmp_words(int base, int g0, logic [31:0] a0, int n, string req);
    logic [31:0] ed;
    for (int i = 0; i < n; i++) begin
      ed = {e565(pxv(g0 + 2*i + 1)), e565(pxv(g0 + 2*i))};
      chk(cap_a[(base + i) % 1024] == a0 + 32'(4*i), "R5 address", cap_a[(base + i) % 1024], a0 + 32'(4*i));
      chk(cap_d[(base + i) % 1024] == ed, req, cap_d[(base + i) % 1024], ed);
    end
  endtask

  initial begin
    int timeout = 150000;
    while (cyc < timeout && !finished) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, timeout);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base, g0, n;
    logic [31:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1;
    chk(!m_write, "R1 m_write", 32'(m_write), 0);
    chk(!fifo_rd, "R1 fifo_rd", 32'(fifo_rd), 0);
    chk(!irq, "R1 irq", 32'(irq), 0);
    for (int a = 0; a < 7; a++) begin
      rd_reg(a, v);
      chk(v == 0, "R1 register zero", v, 0);
    end

    // vector table: full frames
    for (int k = 0; k < NV; k++) begin
      setup(32'(V_START[k]), V_LW[k], V_LINES[k], V_IE[k]);
      rd_reg(4, v);
      chk(v == 32'(V_START[k]), "R5 start readback", v, 32'(V_START[k]));
      wmode = V_WAIT[k][0];
      n = V_LW[k] * V_LINES[k];
      g0 = wr_p;
      base = ncap;
      push(2 * n);
      wr_reg(0, 1);
      wait_done();
      repeat (2) @(negedge clk);
      rd_reg(1, v);
      chk(v[3], "R7 frame done", v, 32'h8);
      chk(irq == V_IE[k][0], "R9 irq gating", 32'(irq), 32'(V_IE[k]));
      chk(ncap - base == n, "R7 word count", 32'(ncap - base), 32'(n));
      cmp_words(base, g0, 32'(V_START[k]) & ~32'h3, n, "R3 packing");
      chk(wr_p == rd_p, "R2 pixels consumed", 32'(wr_p - rd_p), 0);
      clear_done();
      rd_reg(1, v);
      chk(v == 0, "R10 cleared", v, 0);
      chk(!irq, "R9 irq after clear", 32'(irq), 0);
    end
    wmode = 0;

    // R2 threshold: 7 pixels never start a 4-word burst
    setup(32'h6000, 8, 1, 0);
    base = ncap; g0 = wr_p;
    push(7);
    wr_reg(0, 1);
    repeat (40) @(negedge clk);
    chk(ncap == base, "R2 no early burst", 32'(ncap - base), 0);
    chk(fifo_level == 7, "R2 no pop", 32'(fifo_level), 7);
    push(1);
    repeat (60) @(negedge clk);
    chk(ncap - base == 4, "R2 burst after fill", 32'(ncap - base), 4);
    push(8);
    wait_done();
    chk(ncap - base == 8, "R7 frame words", 32'(ncap - base), 8);
    cmp_words(base, g0, 32'h6000, 8, "R3 packing");
    clear_done();

    // R6 short line: 3-word line needs only 6 pixels
    setup(32'h7000, 3, 1, 0);
    base = ncap; g0 = wr_p;
    push(6);
    wr_reg(0, 1);
    repeat (60) @(negedge clk);
    chk(ncap - base == 3, "R6 trimmed burst", 32'(ncap - base), 3);
    rd_reg(1, v);
    chk(v[3], "R6 frame done", v, 32'h8);
    cmp_words(base, g0, 32'h7000, 3, "R6 data");
    clear_done();

    // R8 disable mid-burst
    setup(32'h8000, 8, 1, 0);
    base = ncap; g0 = wr_p;
    push(16);
    wr_reg(0, 1);
    for (int i = 0; i < 200 && ncap == base; i++) @(negedge clk);
    wr_reg(0, 0);
    repeat (60) @(negedge clk);
    chk(ncap - base == 4, "R8 burst finished then stop", 32'(ncap - base), 4);
    chk(fifo_level == 8, "R8 remaining pixels", 32'(fifo_level), 8);
    wr_reg(0, 1);
    wait_done();
    chk(ncap - base == 8, "R8 resume count", 32'(ncap - base), 8);
    cmp_words(base, g0, 32'h8000, 8, "R8 resume data");
    clear_done();

    // R7 back-to-back frames restart at start address
    setup(32'h9000, 2, 1, 1);
    base = ncap;
    push(8);
    wr_reg(0, 1);
    repeat (100) @(negedge clk);
    chk(ncap - base == 4, "R7 two frames", 32'(ncap - base), 4);
    for (int i = 0; i < 4; i++) begin
      st = 32'h9000 + 32'(4 * (i % 2));
      chk(cap_a[(base + i) % 1024] == st, "R7 restart address", cap_a[(base + i) % 1024], st);
    end

    // R9 / R10 interrupt and write-one-to-clear
    chk(irq, "R9 irq high", 32'(irq), 1);
    wr_reg(2, 0);
    chk(!irq, "R9 irq masked", 32'(irq), 0);
    wr_reg(3, 32'h0);
    rd_reg(1, v);
    chk(v[3], "R10 zero write keeps flag", v, 32'h8);
    wr_reg(2, 32'h8);
    wr_reg(3, 32'h8);
    rd_reg(1, v);
    chk(v == 0, "R10 clear", v, 0);
    chk(!irq, "R9 irq low after clear", 32'(irq), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule